// File: doc/BRIEF.md
# Mixed-Page-Size Translation Cache

This block keeps a small, fully associative set of recent virtual-to-physical translations for an address-translation unit. Each slot holds one mapping of 4 KB, 64 KB or 1 MB. The slot's page size sets how many upper virtual-address bits take part in the tag compare and how many low bits pass straight through into the physical address.

A lookup is presented for one cycle, and its answer appears on the response outputs in the next cycle. On a miss, the block raises a one-cycle walk request that carries the virtual address. The external walker later returns the translation on the fill inputs. A fill goes into an empty slot if one exists. Otherwise it replaces the least recently used slot. A lookup that matches more than one slot is reported as a fault and returns no address.

Software can drop cached translations through two write-only trigger registers. One clears the whole cache, for example after a new table base is loaded. The other clears only the slots that cover one given address.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, and respValid, respHit, respFault and walkReq are low. The first lookup after reset misses.
- R2: respValid is high in exactly the cycle after a cycle in which lookupValid was sampled high, and low in every other cycle.
- R3: A slot filled with size code 0 (4 KB) hits when lookupVa[31:12] equals its stored page number. respPa is then the stored frame bits [31:12] joined with lookupVa[11:0].
- R4: A slot with size code 1 (64 KB) compares only lookupVa[31:16]. respPa takes bits [31:16] from the slot and bits [15:0] from lookupVa.
- R5: A slot with size code 2 (1 MB) compares only lookupVa[31:20]. respPa takes bits [31:20] from the slot and bits [19:0] from lookupVa.
- R6: On a miss, respHit is 0 and respPa is 0. walkReq is high in the same cycle as the response, and walkVa equals the looked-up address.
- R7: A fill writes fillPn, fillPpn and fillSize into the lowest-numbered invalid slot, and the mapping is visible from the next cycle. Size code 3 is stored as 4 KB.
- R8: When no slot is invalid, a fill replaces the slot whose most recent fill or single hit is oldest.
- R9: A write to offset 0x0C with regWrData[0]=1 invalidates every slot. The same write with regWrData[0]=0 has no effect.
- R10: A write to offset 0x10 with regWrData[0]=1 invalidates each valid slot whose page, at that slot's own size, contains the address regWrData[31:12]×4096. Other slots are kept. With regWrData[0]=0 the write does nothing.
- R11: When a lookup matches more than one slot, respFault is 1, respHit is 0, respPa is 0 and walkReq stays low.
- R12: A fill in the same cycle as either flush write is discarded.
- R13: Register writes to any offset other than 0x0C and 0x10 change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 32 | Virtual address to translate |
| respValid | output | 1 | Response valid, one cycle after the request |
| respHit | output | 1 | Exactly one slot matched |
| respFault | output | 1 | More than one slot matched |
| respPa | output | 32 | Translated physical address on a hit, else 0 |
| walkReq | output | 1 | Walk request pulse on a miss |
| walkVa | output | 32 | Address to walk |
| fillValid | input | 1 | Walk result strobe |
| fillPn | input | 20 | Virtual page number, VA[31:12] |
| fillPpn | input | 20 | Physical frame number, PA[31:12] |
| fillSize | input | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3 treated as 4 KB |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |

## Verification
The bench builds the block with its default parameters: 8 slots, 8-bit register offsets, and flush triggers at 0x0C and 0x10. With 8 slots, eight fills are enough to fill the cache, so replacement order can be seen from the ports. With 20-bit page numbers, the 4 KB, 64 KB and 1 MB compare boundaries sit at real address bits, so one address can overlap a large slot and a small slot at the same time. That makes the multi-hit fault and the size-aware single-address flush reachable from ordinary lookups and register writes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W  = 32;
  localparam int OFS_W = 12;
  localparam int PN_W  = VA_W - OFS_W;
  localparam int LG_64K = 16;
  localparam int LG_1M  = 20;

  typedef enum logic [1:0] {
    SZ_4K  = 2'b00,
    SZ_64K = 2'b01,
    SZ_1M  = 2'b10,
    SZ_RSV = 2'b11
  } pageSize_e;

  typedef struct packed {
    logic flushAll;
    logic flushOne;
    logic fillEn;
  } xlatStrb_t;

  // Page-number bits that take part in the compare for a given size.
  function automatic logic [PN_W-1:0] keepMask(input pageSize_e sz);
    logic [PN_W-1:0] ones;
    ones = '1;
    case (sz)
      SZ_64K:  keepMask = ones << (LG_64K - OFS_W);
      SZ_1M:   keepMask = ones << (LG_1M - OFS_W);
      default: keepMask = ones;
    endcase
  endfunction

endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xlatStrb_t              strb,
  input  logic [NUM_ENTRIES-1:0] fillSlot,
  input  logic [PN_W-1:0]        fillPn,
  input  logic [PN_W-1:0]        fillPpn,
  input  pageSize_e              fillSize,
  input  logic [VA_W-1:0]        lookupVa,
  input  logic [PN_W-1:0]        flushPn,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [NUM_ENTRIES-1:0] flushVec,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [VA_W-1:0]        selPa
);

  logic [PN_W-1:0] lookupPn;
  logic [VA_W-1:0] entryPa [NUM_ENTRIES];

  assign lookupPn = lookupVa[VA_W-1:OFS_W];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic            vld;
    logic [PN_W-1:0] tag;
    logic [PN_W-1:0] ppn;
    pageSize_e       size;
    logic [PN_W-1:0] keep;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld  <= 1'b0;
        tag  <= '0;
        ppn  <= '0;
        size <= SZ_4K;
      end else if (strb.flushAll) begin
        vld <= 1'b0;
      end else if (strb.flushOne && flushVec[e]) begin
        vld <= 1'b0;
      end else if (strb.fillEn && fillSlot[e]) begin
        vld  <= 1'b1;
        tag  <= fillPn;
        ppn  <= fillPpn;
        size <= (fillSize == SZ_RSV) ? SZ_4K : fillSize;
      end
    end

    assign keep        = keepMask(size);
    assign hitVec[e]   = vld && (((lookupPn ^ tag) & keep) == '0);
    assign flushVec[e] = vld && (((flushPn ^ tag) & keep) == '0);
    assign validVec[e] = vld;
    assign entryPa[e]  = {(ppn & keep) | (lookupPn & ~keep), lookupVa[OFS_W-1:0]};
  end

  always_comb begin
    selPa = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) selPa = selPa | entryPa[i];
    end
  end

  // R9
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validVec == '0));

  // R10
  flush_one_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushOne |=> (($past(flushVec) & validVec) == '0));

  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillEn |=> ((validVec & $past(fillSlot)) != '0));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES   = 8,
  parameter int REG_ADDR_W    = 8,
  parameter int FLUSH_ALL_OFS = 'h0C,
  parameter int FLUSH_ONE_OFS = 'h10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VA_W-1:0]        lookupVa,
  input  logic                   fillValid,
  input  logic                   regWrEn,
  input  logic [REG_ADDR_W-1:0]  regAddr,
  input  logic                   regTrig,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [VA_W-1:0]        selPa,
  output xlatStrb_t              strb,
  output logic [NUM_ENTRIES-1:0] fillSlot,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respFault,
  output logic [VA_W-1:0]        respPa,
  output logic                   walkReq,
  output logic [VA_W-1:0]        walkVa
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0]       age [NUM_ENTRIES];
  logic [CNT_W-1:0]       hitCnt;
  logic [IDX_W-1:0]       hitIdx;
  logic [IDX_W-1:0]       invIdx;
  logic                   anyInv;
  logic [IDX_W-1:0]       oldIdx;
  logic [NUM_ENTRIES-1:0] oldestVec;
  logic [IDX_W-1:0]       victimIdx;
  logic                   flushAllReq;
  logic                   flushOneReq;
  logic                   touchEn;
  logic [IDX_W-1:0]       touchIdx;
  logic                   singleHit;

  // Register decode: bit 0 of the written data is the trigger.
  assign flushAllReq = regWrEn && regTrig && (regAddr == REG_ADDR_W'(FLUSH_ALL_OFS));
  assign flushOneReq = regWrEn && regTrig && (regAddr == REG_ADDR_W'(FLUSH_ONE_OFS));

  always_comb begin
    hitCnt = '0;
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitCnt = hitCnt + CNT_W'(1);
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign singleHit = (hitCnt == CNT_W'(1));

  // Victim: lowest invalid slot first, else the oldest by age.
  always_comb begin
    anyInv    = 1'b0;
    invIdx    = '0;
    oldIdx    = '0;
    oldestVec = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        anyInv = 1'b1;
        invIdx = IDX_W'(i);
      end
      if (age[i] == OLDEST) begin
        oldestVec[i] = 1'b1;
        oldIdx       = IDX_W'(i);
      end
    end
    victimIdx = anyInv ? invIdx : oldIdx;
  end

  always_comb begin
    fillSlot = '0;
    fillSlot[victimIdx] = 1'b1;
  end

  assign strb.flushAll = flushAllReq;
  assign strb.flushOne = flushOneReq;
  assign strb.fillEn   = fillValid && !flushAllReq && !flushOneReq;

  // A fill is the most recent use; otherwise a single hit is.
  always_comb begin
    touchEn  = 1'b0;
    touchIdx = '0;
    if (strb.fillEn) begin
      touchEn  = 1'b1;
      touchIdx = victimIdx;
    end else if (lookupValid && singleHit) begin
      touchEn  = 1'b1;
      touchIdx = hitIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respPa    <= '0;
      walkReq   <= 1'b0;
      walkVa    <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && singleHit;
      respFault <= lookupValid && (hitCnt > CNT_W'(1));
      respPa    <= (lookupValid && singleHit) ? selPa : '0;
      walkReq   <= lookupValid && (hitCnt == '0);
      if (lookupValid) walkVa <= lookupVa;
    end
  end

  // R8
  lru_oldest_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(oldestVec));

  // R6
  walk_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (respValid && !respHit && !respFault));

  // R2
  resp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R11
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (!respHit && (respPa == '0) && !walkReq));

  // R12
  fill_dropped_on_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && flushAllReq) |=> (validVec == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES   = 8,
  parameter int REG_ADDR_W    = 8,
  parameter int FLUSH_ALL_OFS = 'h0C,
  parameter int FLUSH_ONE_OFS = 'h10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lookupValid,
  input  logic [31:0]           lookupVa,
  output logic                  respValid,
  output logic                  respHit,
  output logic                  respFault,
  output logic [31:0]           respPa,
  output logic                  walkReq,
  output logic [31:0]           walkVa,
  input  logic                  fillValid,
  input  logic [19:0]           fillPn,
  input  logic [19:0]           fillPpn,
  input  logic [1:0]            fillSize,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWrData
);

  xlatStrb_t              strb;
  logic [NUM_ENTRIES-1:0] fillSlot;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] flushVec;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [VA_W-1:0]        selPa;
  logic                   unusedRegBits;

  assign unusedRegBits = ^{regWrData[OFS_W-1:1], flushVec};

  xlat_ctrl #(
    .NUM_ENTRIES  (NUM_ENTRIES),
    .REG_ADDR_W   (REG_ADDR_W),
    .FLUSH_ALL_OFS(FLUSH_ALL_OFS),
    .FLUSH_ONE_OFS(FLUSH_ONE_OFS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lookupValid(lookupValid),
    .lookupVa   (lookupVa),
    .fillValid  (fillValid),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regTrig    (regWrData[0]),
    .hitVec     (hitVec),
    .validVec   (validVec),
    .selPa      (selPa),
    .strb       (strb),
    .fillSlot   (fillSlot),
    .respValid  (respValid),
    .respHit    (respHit),
    .respFault  (respFault),
    .respPa     (respPa),
    .walkReq    (walkReq),
    .walkVa     (walkVa)
  );

  xlat_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .fillSlot(fillSlot),
    .fillPn  (fillPn),
    .fillPpn (fillPpn),
    .fillSize(pageSize_e'(fillSize)),
    .lookupVa(lookupVa),
    .flushPn (regWrData[VA_W-1:OFS_W]),
    .hitVec  (hitVec),
    .flushVec(flushVec),
    .validVec(validVec),
    .selPa   (selPa)
  );

endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic        respValid, respHit, respFault, walkReq;
  logic [31:0] respPa, walkVa;
  logic        fillValid = 1'b0;
  logic [19:0] fillPn = '0;
  logic [19:0] fillPpn = '0;
  logic [1:0]  fillSize = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVa(lookupVa),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respPa(respPa), .walkReq(walkReq), .walkVa(walkVa),
    .fillValid(fillValid), .fillPn(fillPn), .fillPpn(fillPpn), .fillSize(fillSize),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData)
  );

  localparam int VW = 102;
  localparam logic [1:0] OP_LK = 2'd0, OP_FL = 2'd1, OP_WR = 2'd2;
  localparam int K_MISS = 0, K_HIT = 1, K_FLT = 2;

  function automatic logic [VW-1:0] mkv(input logic [1:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [1:0] sz, input logic [1:0] ex, input logic [31:0] pa);
    return {op, a, b, sz, ex, pa};
  endfunction

  localparam int NV = 34;
  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(OP_LK, 32'h0000_1234, 0, 0, 0, 0),                          // R1 R6
    mkv(OP_FL, 32'h0000_1000, 32'h8000_5000, 0, 0, 0),
    mkv(OP_LK, 32'h0000_1ABC, 0, 0, 1, 32'h8000_5ABC),              // R3
    mkv(OP_LK, 32'h0000_2ABC, 0, 0, 0, 0),                          // R3
    mkv(OP_FL, 32'h0012_0000, 32'h4034_0000, 1, 0, 0),
    mkv(OP_LK, 32'h0012_F00D, 0, 0, 1, 32'h4034_F00D),              // R4
    mkv(OP_LK, 32'h0013_0000, 0, 0, 0, 0),                          // R4
    mkv(OP_LK, 32'h0011_FFFF, 0, 0, 0, 0),                          // R4
    mkv(OP_FL, 32'h123A_B000, 32'hABCD_E000, 2, 0, 0),
    mkv(OP_LK, 32'h123F_FFFF, 0, 0, 1, 32'hABCF_FFFF),              // R5
    mkv(OP_LK, 32'h1240_0000, 0, 0, 0, 0),                          // R5
    mkv(OP_LK, 32'h1230_0000, 0, 0, 1, 32'hABC0_0000),              // R5
    mkv(OP_WR, 32'h0000_000C, 32'h0000_0000, 0, 0, 0),
    mkv(OP_LK, 32'h0000_1ABC, 0, 0, 1, 32'h8000_5ABC),              // R9 trigger clear
    mkv(OP_WR, 32'h0000_0010, 32'h0012_F001, 0, 0, 0),
    mkv(OP_LK, 32'h0012_0000, 0, 0, 0, 0),                          // R10 64K gone
    mkv(OP_LK, 32'h0000_1ABC, 0, 0, 1, 32'h8000_5ABC),              // R10 kept
    mkv(OP_LK, 32'h1234_5678, 0, 0, 1, 32'hABC4_5678),              // R10 kept
    mkv(OP_WR, 32'h0000_0014, 32'h0000_0001, 0, 0, 0),
    mkv(OP_LK, 32'h0000_1ABC, 0, 0, 1, 32'h8000_5ABC),              // R13
    mkv(OP_WR, 32'h0000_0010, 32'h0000_1000, 0, 0, 0),
    mkv(OP_LK, 32'h0000_1FFF, 0, 0, 1, 32'h8000_5FFF),              // R10 trigger clear
    mkv(OP_FL, 32'h1230_0000, 32'h1111_1000, 0, 0, 0),
    mkv(OP_LK, 32'h1230_0010, 0, 0, 2, 32'h0),                      // R11
    mkv(OP_LK, 32'h1231_0000, 0, 0, 1, 32'hABC1_0000),              // R11 single
    mkv(OP_FL, 32'h0000_3000, 32'h2222_2000, 3, 0, 0),
    mkv(OP_LK, 32'h0000_3004, 0, 0, 1, 32'h2222_2004),              // R7
    mkv(OP_LK, 32'h0000_4004, 0, 0, 0, 0),                          // R7 code 3 is 4K
    mkv(OP_WR, 32'h0000_0010, 32'h1230_0001, 0, 0, 0),
    mkv(OP_LK, 32'h123F_FFFF, 0, 0, 0, 0),                          // R10 1M gone
    mkv(OP_LK, 32'h1230_0010, 0, 0, 0, 0),                          // R10 4K gone
    mkv(OP_WR, 32'h0000_000C, 32'h0000_0001, 0, 0, 0),
    mkv(OP_LK, 32'h0000_1ABC, 0, 0, 0, 0),                          // R9
    mkv(OP_LK, 32'h0000_3004, 0, 0, 0, 0)                           // R9
  };

  task automatic doLookup(input logic [31:0] va, input int kind, input logic [31:0] expPa,
                          input string tag);
    bit ok;
    @(negedge clk);
    lookupValid = 1'b1;
    lookupVa    = va;
    @(negedge clk);
    lookupValid = 1'b0;
    checks++;
    ok = respValid && (respHit == (kind == K_HIT)) && (respFault == (kind == K_FLT)) &&
         (respPa == expPa) && (walkReq == (kind == K_MISS)) &&
         ((kind != K_MISS) || (walkVa == va));
    if (!ok) begin
      errors++;
      $display("FAIL %s va=%h got v=%0b hit=%0b flt=%0b pa=%h walk=%0b wva=%h exp kind=%0d pa=%h",
               tag, va, respValid, respHit, respFault, respPa, walkReq, walkVa, kind, expPa);
    end
  endtask

  task automatic doFill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fillValid = 1'b1;
    fillPn    = va[31:12];
    fillPpn   = pa[31:12];
    fillSize  = sz;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] ofs, input logic [31:0] data);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = ofs;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkBit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during and right after reset
    repeat (3) @(negedge clk);
    chkBit("R1 respValid in reset", respValid, 1'b0);
    chkBit("R1 walkReq in reset", walkReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkBit("R1 respHit after reset", respHit, 1'b0);
    chkBit("R1 respFault after reset", respFault, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      case (v[101:100])
        OP_LK:   doLookup(v[99:68], int'(v[33:32]), v[31:0], $sformatf("table[%0d]", i));
        OP_FL:   doFill(v[99:68], v[67:36], v[35:34]);
        default: doWrite(v[75:68], v[67:36]);
      endcase
    end

    // R2: response only in the cycle after a lookup
    doLookup(32'h0000_5000, K_MISS, 32'h0, "R2 lookup");
    @(negedge clk);
    chkBit("R2 respValid idle", respValid, 1'b0);
    chkBit("R6 walkReq idle", walkReq, 1'b0);

    // R12: fill together with flush-all is dropped
    @(negedge clk);
    fillValid = 1'b1; fillPn = 20'h00006; fillPpn = 20'h33333; fillSize = 2'd0;
    regWrEn = 1'b1; regAddr = 8'h0C; regWrData = 32'h1;
    @(negedge clk);
    fillValid = 1'b0; regWrEn = 1'b0;
    doLookup(32'h0000_6000, K_MISS, 32'h0, "R12 flush-all beats fill");
    // R12: fill together with an unrelated single-address flush is dropped
    @(negedge clk);
    fillValid = 1'b1; fillPn = 20'h00006; fillPpn = 20'h33333; fillSize = 2'd0;
    regWrEn = 1'b1; regAddr = 8'h10; regWrData = 32'h7000_0001;
    @(negedge clk);
    fillValid = 1'b0; regWrEn = 1'b0;
    doLookup(32'h0000_6000, K_MISS, 32'h0, "R12 flush-one beats fill");
    doFill(32'h0000_6000, 32'h3333_3000, 2'd0);
    doLookup(32'h0000_6010, K_HIT, 32'h3333_3010, "R7 plain fill");

    // R8: least-recently-used replacement
    doWrite(8'h0C, 32'h1);
    for (int p = 0; p < 8; p++) doFill(32'(p) << 12, 32'h9000_0000 + (32'(p) << 12), 2'd0);
    doLookup(32'h0000_0008, K_HIT, 32'h9000_0008, "R8 touch page0");
    doFill(32'h0000_8000, 32'h9000_8000, 2'd0);
    doLookup(32'h0000_1000, K_MISS, 32'h0, "R8 page1 evicted");
    doLookup(32'h0000_0000, K_HIT, 32'h9000_0000, "R8 page0 kept");
    doLookup(32'h0000_8000, K_HIT, 32'h9000_8000, "R8 page8 present");
    doLookup(32'h0000_7000, K_HIT, 32'h9000_7000, "R8 page7 kept");
    doFill(32'h0000_9000, 32'h9000_9000, 2'd0);
    doLookup(32'h0000_2000, K_MISS, 32'h0, "R8 page2 evicted");
    doLookup(32'h0000_3000, K_HIT, 32'h9000_3000, "R8 page3 kept");
    doLookup(32'h0000_9000, K_HIT, 32'h9000_9000, "R8 page9 present");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule